// File: doc/BRIEF.md
# Status Word Flag Update Unit

This block keeps an eight-bit processor status byte and refreshes its condition flags from byte-wide arithmetic. Each clock cycle it takes one operation code and two operands. It then computes the arithmetic result and updates four flags: carry or borrow, nibble carry, signed overflow and odd parity. All of this is registered at the clock edge, so the new status byte and the new result appear together in the next cycle.

A write operation loads the whole status byte from an operand. Software uses this to set the two user flags and the two bank-select bits. The bank-select bits pick one of four eight-byte register banks, and the block reports the base address of the selected bank. A compare operation updates the flags without producing a result. Multiply and divide also drive a second output byte: the high byte of the product, or the remainder.

Top module: `status_flag_unit`

## Requirements
- R1: After a clock edge with `rst` high, the status byte is 00h, `result` and `result_hi` are 00h, `res_valid` is 0 and `bank_base` is 00h.
- R2: Opcode 1 (add) and opcode 2 (add with carry) produce `result` = (a + b + cin) mod 256. Here cin is the current carry bit (bit 7) for opcode 2 and 0 for opcode 1. Bit 7 becomes 1 exactly when the sum exceeds FFh.
- R3: Opcode 3 (subtract) and opcode 4 (subtract with borrow) produce `result` = (a - b - bin) mod 256. Here bin is the current bit 7 for opcode 4 and 0 for opcode 3. Bit 7 becomes 1 exactly when a < b + bin.
- R4: On opcodes 1 to 5, bit 6 becomes 1 when the low four bits carry out (addition) or need a borrow (subtraction). Otherwise bit 6 becomes 0.
- R5: On opcodes 1 to 5, bit 2 becomes 1 exactly when the signed two's-complement result lies outside -128..127.
- R6: Opcode 5 (compare) updates bits 7, 6 and 2 exactly as opcode 3 would. It leaves `result` unchanged and `res_valid` low.
- R7: Opcode 6 (multiply) gives the low byte of a*b on `result` and the high byte on `result_hi`. It sets bit 2 to 1 exactly when the high byte is nonzero, clears bit 7 and leaves bit 6 unchanged.
- R8: Opcode 7 (divide) gives the quotient on `result` and the remainder on `result_hi`, clears bit 7 and clears bit 2. When b is zero, both outputs are FFh and bit 2 is set.
- R9: When `par_en` is high on opcodes 1, 2, 3, 4, 6 or 7, bit 0 becomes the XOR of all bits of the new `result`. On every other cycle except a write, bit 0 is unchanged.
- R10: Opcode 8 (write) loads `opnd_a` into all eight status bits in one cycle and leaves `res_valid` low.
- R11: Bits 5 and 1 (user flags) and bits 4:3 (bank select) change only through opcode 8.
- R12: `bank_base` equals 8 times the bank-select value, where bit 4 is its high bit and bit 3 is its low bit. This gives 00h, 08h, 10h or 18h.
- R13: Opcode 0 and opcodes 9 to 15 leave the status byte, `result` and `result_hi` unchanged and keep `res_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| opnd_a | input | 8 | First operand, or the write data for opcode 8 |
| opnd_b | input | 8 | Second operand |
| par_en | input | 1 | Enables the parity refresh |
| status | output | 8 | Status byte: CY7 AC6 U1(5) BS1(4) BS0(3) OV2 U0(1) P0 |
| result | output | 8 | Registered arithmetic result |
| res_valid | output | 1 | High for one cycle after a result-producing operation |
| result_hi | output | 8 | Product high byte or remainder |
| bank_base | output | 8 | Base address of the selected register bank |

## Verification
Every result is due one cycle after its inputs. The operands and opcode are sampled at a rising edge, and `status`, `result`, `result_hi` and `res_valid` change at that same edge. `bank_base` follows the registered bank-select bits with no further delay. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares all five outputs at the next falling edge, so each comparison sees the first cycle in which the new values are due. Since carry-in and borrow-in come from the previous flag state, back-to-back operations are run without gaps so that this chaining is checked as well.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADDC = 4'd2,
    OP_SUB  = 4'd3,
    OP_SUBB = 4'd4,
    OP_CMP  = 4'd5,
    OP_MUL  = 4'd6,
    OP_DIV  = 4'd7,
    OP_WR   = 4'd8
  } sfu_op_e;

  localparam int ST_W    = 8;
  localparam int CY_B    = 7;
  localparam int AC_B    = 6;
  localparam int U1_B    = 5;
  localparam int BS_HI_B = 4;
  localparam int BS_LO_B = 3;
  localparam int OV_B    = 2;
  localparam int U0_B    = 1;
  localparam int P_B     = 0;
endpackage

// File: rtl/sfu_addsub.sv
module sfu_addsub #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cy,
  output logic              ac,
  output logic              ov
);
  localparam int NIB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] b_x;
  logic              c_x;
  logic [DATA_W:0]   full;
  logic [NIB:0]      low;

  always_comb begin
    // subtraction is done as a + ~b + ~borrow
    b_x  = sub ? ~b : b;
    c_x  = sub ? ~cin : cin;
    full = {1'b0, a} + {1'b0, b_x} + {{DATA_W{1'b0}}, c_x};
    low  = {1'b0, a[NIB-1:0]} + {1'b0, b_x[NIB-1:0]} + {{NIB{1'b0}}, c_x};
    sum  = full[DATA_W-1:0];
    cy   = full[DATA_W] ^ sub;
    ac   = low[NIB] ^ sub;
    ov   = (a[MSB] == b_x[MSB]) && (full[MSB] != a[MSB]);
  end
endmodule

// File: rtl/sfu_muldiv.sv
module sfu_muldiv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] mul_lo,
  output logic [DATA_W-1:0] mul_hi,
  output logic              mul_ovf,
  output logic [DATA_W-1:0] quot,
  output logic [DATA_W-1:0] rem,
  output logic              div_zero
);
  localparam int PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod    = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    mul_lo  = prod[DATA_W-1:0];
    mul_hi  = prod[PROD_W-1:DATA_W];
    mul_ovf = |mul_hi;
    div_zero = (b == '0);
    if (div_zero) begin
      quot = '1;
      rem  = '1;
    end else begin
      quot = a / b;
      rem  = a % b;
    end
  end
endmodule

// File: rtl/sfu_bank.sv
module sfu_bank #(
  parameter int ADDR_W    = 8,
  parameter int BANK_SPAN = 8
) (
  input  logic [1:0]        bank_sel,
  output logic [ADDR_W-1:0] base
);
  localparam int SHIFT = $clog2(BANK_SPAN);

  assign base = ADDR_W'(bank_sel) << SHIFT;
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int BANK_SPAN = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              par_en,
  output logic [ST_W-1:0]   status,
  output logic [DATA_W-1:0] result,
  output logic              res_valid,
  output logic [DATA_W-1:0] result_hi,
  output logic [ADDR_W-1:0] bank_base
);
  logic [ST_W-1:0]   st_q, st_d;
  logic [DATA_W-1:0] res_q, res_d, hi_q, hi_d;
  logic              vld_q, vld_d;
  logic              par_upd;

  logic              as_cin, as_sub;
  logic [DATA_W-1:0] as_sum;
  logic              as_cy, as_ac, as_ov;

  logic [DATA_W-1:0] md_lo, md_hi, md_q, md_r;
  logic              md_movf, md_dz;

  assign as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) ? st_q[CY_B] : 1'b0;
  assign as_sub = (op == OP_SUB) || (op == OP_SUBB) || (op == OP_CMP);

  sfu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a   (opnd_a),
    .b   (opnd_b),
    .cin (as_cin),
    .sub (as_sub),
    .sum (as_sum),
    .cy  (as_cy),
    .ac  (as_ac),
    .ov  (as_ov)
  );

  sfu_muldiv #(.DATA_W(DATA_W)) u_muldiv (
    .a        (opnd_a),
    .b        (opnd_b),
    .mul_lo   (md_lo),
    .mul_hi   (md_hi),
    .mul_ovf  (md_movf),
    .quot     (md_q),
    .rem      (md_r),
    .div_zero (md_dz)
  );

  sfu_bank #(.ADDR_W(ADDR_W), .BANK_SPAN(BANK_SPAN)) u_bank (
    .bank_sel (st_q[BS_HI_B:BS_LO_B]),
    .base     (bank_base)
  );

  always_comb begin
    st_d    = st_q;
    res_d   = res_q;
    hi_d    = hi_q;
    vld_d   = 1'b0;
    par_upd = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBB: begin
        st_d[CY_B] = as_cy;
        st_d[AC_B] = as_ac;
        st_d[OV_B] = as_ov;
        res_d      = as_sum;
        vld_d      = 1'b1;
        par_upd    = 1'b1;
      end
      OP_CMP: begin
        st_d[CY_B] = as_cy;
        st_d[AC_B] = as_ac;
        st_d[OV_B] = as_ov;
      end
      OP_MUL: begin
        st_d[CY_B] = 1'b0;
        st_d[OV_B] = md_movf;
        res_d      = md_lo;
        hi_d       = md_hi;
        vld_d      = 1'b1;
        par_upd    = 1'b1;
      end
      OP_DIV: begin
        st_d[CY_B] = 1'b0;
        st_d[OV_B] = md_dz;
        res_d      = md_q;
        hi_d       = md_r;
        vld_d      = 1'b1;
        par_upd    = 1'b1;
      end
      OP_WR: begin
        st_d = opnd_a[ST_W-1:0];
      end
      default: begin
      end
    endcase
    if (par_upd && par_en) begin
      st_d[P_B] = ^res_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= '0;
      res_q <= '0;
      hi_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      res_q <= res_d;
      hi_q  <= hi_d;
      vld_q <= vld_d;
    end
  end

  assign status    = st_q;
  assign result    = res_q;
  assign result_hi = hi_q;
  assign res_valid = vld_q;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker
  import sfu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              par_en,
  input logic [ST_W-1:0]   status,
  input logic [DATA_W-1:0] result,
  input logic              res_valid,
  input logic [DATA_W-1:0] result_hi,
  input logic [ADDR_W-1:0] bank_base
);
  // R10
  wr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_WR) |=> (status == $past(opnd_a[ST_W-1:0])) && !res_valid);

  // R6
  cmp_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_CMP) |=> !res_valid && $stable(result));

  // R7
  mul_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_MUL) |=> !status[CY_B] && (status[AC_B] == $past(status[AC_B])));

  // R8
  div_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_DIV && opnd_b == '0) |=> status[OV_B] && (result == '1) && (result_hi == '1));

  // R11
  user_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (op != OP_WR) |=> $stable(status[U1_B]) && $stable(status[U0_B]) && $stable(bank_base));

  // R9
  parity_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!par_en && op != OP_WR) |=> $stable(status[P_B]));

  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_NOP || op > OP_WR) |=> $stable(status) && $stable(result) && !res_valid);

  // R12
  bank_align_chk: assert property (@(posedge clk) disable iff (rst)
    bank_base[2:0] == 3'b000 && bank_base < ADDR_W'(32));
endmodule

bind status_flag_unit sfu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op        (op),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .par_en    (par_en),
  .status    (status),
  .result    (result),
  .res_valid (res_valid),
  .result_hi (result_hi),
  .bank_base (bank_base)
);

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] op;
  logic [7:0] opnd_a, opnd_b;
  logic       par_en;
  logic [7:0] status, result, result_hi, bank_base;
  logic       res_valid;

  int compared = 0;
  int mismatched = 0;

  int m_st, m_res, m_hi, m_vld;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_flag_unit dut (
    .clk(clk), .rst(rst), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .par_en(par_en), .status(status), .result(result), .res_valid(res_valid),
    .result_hi(result_hi), .bank_base(bank_base)
  );

  function automatic int sgn(input int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int odd_bits(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n & 1;
  endfunction

  function automatic int setb(input int w, input int pos, input int val);
    return val != 0 ? (w | (1 << pos)) : (w & ~(1 << pos));
  endfunction

  task automatic cmp1(input string tag, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp1(tag, "status", int'(status), m_st);
    cmp1(tag, "result", int'(result), m_res);
    cmp1(tag, "result_hi", int'(result_hi), m_hi);
    cmp1(tag, "res_valid", int'(res_valid), m_vld);
    cmp1(tag, "bank_base", int'(bank_base), ((m_st >> 3) & 3) * 8);
  endtask

  task automatic model(input int o, input int a, input int b, input bit pe);
    int cy, full, sf, prod_res;
    bit makes;
    cy = (m_st >> 7) & 1;
    makes = 1'b0;
    m_vld = 0;
    case (o)
      1, 2: begin
        int ci = (o == 2) ? cy : 0;
        full = a + b + ci;
        sf = sgn(a) + sgn(b) + ci;
        m_st = setb(m_st, 7, full > 255);
        m_st = setb(m_st, 6, (a % 16) + (b % 16) + ci > 15);
        m_st = setb(m_st, 2, sf > 127 || sf < -128);
        m_res = full % 256; m_vld = 1; makes = 1'b1;
      end
      3, 4, 5: begin
        int bi = (o == 4) ? cy : 0;
        full = a - b - bi;
        sf = sgn(a) - sgn(b) - bi;
        m_st = setb(m_st, 7, full < 0);
        m_st = setb(m_st, 6, (a % 16) - (b % 16) - bi < 0);
        m_st = setb(m_st, 2, sf > 127 || sf < -128);
        if (o != 5) begin
          m_res = (full + 256) % 256; m_vld = 1; makes = 1'b1;
        end
      end
      6: begin
        prod_res = a * b;
        m_res = prod_res % 256; m_hi = prod_res / 256;
        m_st = setb(m_st, 7, 0);
        m_st = setb(m_st, 2, m_hi != 0);
        m_vld = 1; makes = 1'b1;
      end
      7: begin
        if (b == 0) begin
          m_res = 255; m_hi = 255; m_st = setb(m_st, 2, 1);
        end else begin
          m_res = a / b; m_hi = a % b; m_st = setb(m_st, 2, 0);
        end
        m_st = setb(m_st, 7, 0);
        m_vld = 1; makes = 1'b1;
      end
      8: m_st = a;
      default: ;
    endcase
    if (makes && pe) m_st = setb(m_st, 0, odd_bits(m_res));
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input int o, input int a, input int b, input bit pe, input string tag);
    op = o[3:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; par_en = pe;
    @(posedge clk);
    model(o, a, b, pe);
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst = 1'b1; op = 4'd0; opnd_a = 8'h00; opnd_b = 8'h00; par_en = 1'b0;
    m_st = 0; m_res = 0; m_hi = 0; m_vld = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1 reset");

    step(1, 8'h0F, 8'h01, 1, "R4 add nibble carry");
    step(1, 8'hFF, 8'h01, 1, "R2 add carry out");
    step(2, 8'h10, 8'h20, 1, "R2 addc uses carry");
    step(1, 8'hFF, 8'h01, 0, "R2 set carry");
    step(1, 8'h01, 8'h01, 0, "R2 add ignores carry");
    step(1, 8'h7F, 8'h01, 1, "R5 add signed overflow");
    step(1, 8'h80, 8'h80, 1, "R5 add negative overflow");
    step(3, 8'h10, 8'h01, 1, "R4 sub nibble borrow");
    step(3, 8'h00, 8'h01, 1, "R3 sub borrow");
    step(4, 8'h05, 8'h01, 1, "R3 subb uses borrow");
    step(3, 8'h80, 8'h01, 1, "R5 sub overflow");
    step(5, 8'h01, 8'h02, 1, "R6 compare");
    step(5, 8'h7F, 8'hFF, 1, "R6 compare overflow");
    step(6, 8'h10, 8'h10, 1, "R7 multiply overflow");
    step(6, 8'h03, 8'h04, 1, "R7 multiply small");
    step(7, 8'h07, 8'h00, 1, "R8 divide by zero");
    step(7, 8'd100, 8'd7, 1, "R8 divide");
    step(1, 8'h01, 8'h02, 0, "R9 parity held");
    step(1, 8'h01, 8'h02, 1, "R9 parity refreshed");
    step(8, 8'hFF, 8'h00, 0, "R10 write all ones");
    step(8, 8'h18, 8'h00, 0, "R12 bank 3");
    step(8, 8'h08, 8'h00, 0, "R12 bank 1");
    step(8, 8'h10, 8'h00, 0, "R12 bank 2");
    step(8, 8'h22, 8'h00, 0, "R10 write user bits");
    step(1, 8'hF0, 8'h33, 1, "R11 add keeps user bits");
    step(6, 8'hFF, 8'hFF, 1, "R11 multiply keeps user bits");
    step(0, 8'h12, 8'h34, 1, "R13 no-op");
    step(15, 8'h12, 8'h34, 1, "R13 unused code");
    step(9, 8'hAA, 8'h55, 1, "R13 unused code 9");

    for (int i = 0; i < 400; i++) begin
      int o = $urandom_range(0, 15);
      if (o > 8 && ($urandom_range(0, 3) != 0)) o = $urandom_range(1, 7);
      step(o, $urandom_range(0, 255), ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(0, 255),
           bit'($urandom_range(0, 1)), "R5 mixed sequence");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule